// File: doc/BRIEF.md
# Two-Speed Oscillator Start-Up Switch

This block chooses the clock that drives a processor core when the core leaves its low-power sleep state. It receives a free-running fast internal oscillator clock, an external oscillator clock, a 3-bit oscillator-mode code, a wake pulse and a sleep pulse. After reset the core clock is held stopped until the first wake.

On wake in a crystal mode, the core runs from the internal clock straight away. Meanwhile a start-up timer in the external clock domain counts external periods. When the count completes, a break-before-make switch moves the core onto the external clock, and a status pin reports the change.

Modes that need no stabilisation skip the timer. External-clock and RC modes go straight to the external source. The internal-oscillator mode stays on the internal clock.

The sleep and wake pulses and the mode code are synchronous to the internal clock. Each pulse lasts one cycle.

Top module: `tss_start_switch`

## Requirements
- R1: After reset, and before the first wake, the core clock output is stopped (held low) and the status output `on_ext_o` is 0.
- R2: On a wake pulse in a crystal mode (`osc_mode_i` code 0, 1 or 2), the core clock follows the internal clock within a few internal cycles, and `on_ext_o` stays 0.
- R3: In a crystal mode the core stays on the internal clock until STARTUP_CYCLES (default 1024) external periods have elapsed since the wake.
- R4: Once the start-up count completes, the core clock follows the external clock and `on_ext_o` reads 1.
- R5: On a wake pulse with code 3 (external clock) or code 4 (RC), the core moves to the external clock with no start-up count and `on_ext_o` reads 1 within a few tens of external cycles.
- R6: On a wake pulse with code 5 (internal oscillator), or with an unused code 6 or 7, the core runs from the internal clock and stays there indefinitely with `on_ext_o` at 0.
- R7: A wake pulse while the start-up count is running restarts the count from zero. The switch to the external clock then comes STARTUP_CYCLES external periods after the newer pulse.
- R8: A sleep pulse stops the core clock output and clears `on_ext_o`. A sleep pulse and a wake pulse in the same cycle act as sleep.
- R9: The switch is glitch-free. The two clock enables are never on together, and no high or low phase of the core clock is shorter than the shorter half-period of the two sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int | input | 1 | Fast internal oscillator clock, free-running |
| clk_ext | input | 1 | External oscillator clock, free-running |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| sleep_i | input | 1 | One-cycle pulse (internal domain): enter sleep |
| wake_i | input | 1 | One-cycle pulse (internal domain): leave sleep or restart the count |
| osc_mode_i | input | 3 | Mode code: 0 LP, 1 XT, 2 HS, 3 external clock, 4 RC, 5 internal |
| core_clk_o | output | 1 | Gated clock delivered to the core |
| on_ext_o | output | 1 | 1 while the core runs from the external clock |

## Verification
The bench builds the block with the default STARTUP_CYCLES of 1024 and SYNC_STAGES of 2. The external clock is set 2.5 times slower than the internal one, so the two sources can be told apart by counting core clock edges over a fixed window.

With the full 1024-cycle count, the bench can sample just before the switch point (1000 periods) and just after it (1060 periods). The restart case moves that point by 600 periods, which is easy to separate from the original switch time. Every core clock edge is timed, so a runt phase from a faulty handover shows up as a short interval.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [1:0] {
    ST_SLEEP   = 2'd0,
    ST_WARM    = 2'd1,
    ST_RUN_INT = 2'd2,
    ST_RUN_EXT = 2'd3
  } sw_state_e;

  // Crystal modes (codes 0..2) need the start-up count.
  function automatic logic needs_count(input logic [2:0] mode);
    return mode <= 3'd2;
  endfunction

  // External clock (3) and RC (4) go straight to the external source.
  function automatic logic direct_ext(input logic [2:0] mode);
    return (mode == 3'd3) || (mode == 3'd4);
  endfunction

endpackage

// File: rtl/tss_sync.sv
module tss_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/tss_ost_timer.sv
// External-domain start-up timer. A change of the request tag starts
// a fresh count; the tag is echoed back once the count completes.
module tss_ost_timer #(
  parameter int STARTUP_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk_ext,
  input  logic rst_n,
  input  logic run_i,
  input  logic tag_i,
  output logic busy_o,
  output logic ack_o
);

  localparam int CW = $clog2(STARTUP_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(STARTUP_CYCLES - 1);

  logic          run_s, tag_s, seen_q;
  logic [CW-1:0] cnt_q;

  tss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_in_sync (
    .clk   (clk_ext),
    .rst_n (rst_n),
    .d     ({run_i, tag_i}),
    .q     ({run_s, tag_s})
  );

  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      busy_o <= 1'b0;
      ack_o  <= 1'b0;
      cnt_q  <= '0;
    end else if (!run_s) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (tag_s != seen_q) begin
      seen_q <= tag_s;
      busy_o <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (cnt_q == LAST) begin
        busy_o <= 1'b0;
        ack_o  <= seen_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tss_ctrl.sv
// Internal-domain sequencer: picks which source the core should use.
module tss_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk_int,
  input  logic                rst_n,
  input  logic                sleep_i,
  input  logic                wake_i,
  input  logic [2:0]          mode_i,
  input  logic                busy_i,
  input  logic                ack_i,
  output logic                want_int_o,
  output logic                want_ext_o,
  output logic                ost_run_o,
  output logic                ost_tag_o,
  output tss_pkg::sw_state_e  state_o
);
  import tss_pkg::*;

  sw_state_e state_q;
  logic      tag_q, seen_busy_q, busy_s, ack_s, count_done;

  tss_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_back_sync (
    .clk   (clk_int),
    .rst_n (rst_n),
    .d     ({busy_i, ack_i}),
    .q     ({busy_s, ack_s})
  );

  // Completion counts only after the timer was seen busy for this tag.
  assign count_done = (state_q == ST_WARM) && seen_busy_q && !busy_s && (ack_s == tag_q);

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_SLEEP;
      tag_q       <= 1'b0;
      seen_busy_q <= 1'b0;
    end else begin
      if (busy_s) seen_busy_q <= 1'b1;
      if (sleep_i) begin
        state_q <= ST_SLEEP;
      end else if (wake_i && (state_q == ST_SLEEP || state_q == ST_WARM)) begin
        if (needs_count(mode_i)) begin
          state_q     <= ST_WARM;
          tag_q       <= ~tag_q;
          seen_busy_q <= 1'b0;
        end else if (direct_ext(mode_i)) begin
          state_q <= ST_RUN_EXT;
        end else begin
          state_q <= ST_RUN_INT;
        end
      end else if (count_done) begin
        state_q <= ST_RUN_EXT;
      end
    end
  end

  assign want_int_o = (state_q == ST_WARM) || (state_q == ST_RUN_INT);
  assign want_ext_o = (state_q == ST_RUN_EXT);
  assign ost_run_o  = (state_q == ST_WARM);
  assign ost_tag_o  = tag_q;
  assign state_o    = state_q;

endmodule

// File: rtl/tss_clk_switch.sv
// Break-before-make clock selector: each leg syncs its request in its own
// domain and updates its enable on the falling edge of its own clock.
module tss_clk_switch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic want_int_i,
  input  logic want_ext_i,
  output logic core_clk_o,
  output logic en_int_o,
  output logic en_ext_o
);

  localparam int LEGS = 2;

  logic [LEGS-1:0] clk_v, want_v, en_v;

  assign clk_v  = {clk_ext, clk_int};
  assign want_v = {want_ext_i, want_int_i};

  for (genvar b = 0; b < LEGS; b++) begin : g_leg
    logic req, req_s, en_q;

    assign req = want_v[b] & ~en_v[LEGS-1-b];

    tss_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_req_sync (
      .clk   (clk_v[b]),
      .rst_n (rst_n),
      .d     (req),
      .q     (req_s)
    );

    always_ff @(negedge clk_v[b] or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= req_s;
    end

    assign en_v[b] = en_q;
  end

  assign core_clk_o = |(clk_v & en_v);
  assign en_int_o   = en_v[0];
  assign en_ext_o   = en_v[1];

endmodule

// File: rtl/tss_start_switch.sv
module tss_start_switch #(
  parameter int STARTUP_CYCLES = 1024,
  parameter int SYNC_STAGES    = 2
) (
  input  logic       clk_int,
  input  logic       clk_ext,
  input  logic       rst_n,
  input  logic       sleep_i,
  input  logic       wake_i,
  input  logic [2:0] osc_mode_i,
  output logic       core_clk_o,
  output logic       on_ext_o
);

  tss_pkg::sw_state_e sw_state;
  logic want_int, want_ext, ost_run, ost_tag, ost_busy, ost_ack;
  logic en_int, en_ext;

  tss_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk_int    (clk_int),
    .rst_n      (rst_n),
    .sleep_i    (sleep_i),
    .wake_i     (wake_i),
    .mode_i     (osc_mode_i),
    .busy_i     (ost_busy),
    .ack_i      (ost_ack),
    .want_int_o (want_int),
    .want_ext_o (want_ext),
    .ost_run_o  (ost_run),
    .ost_tag_o  (ost_tag),
    .state_o    (sw_state)
  );

  tss_ost_timer #(.STARTUP_CYCLES(STARTUP_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_timer (
    .clk_ext (clk_ext),
    .rst_n   (rst_n),
    .run_i   (ost_run),
    .tag_i   (ost_tag),
    .busy_o  (ost_busy),
    .ack_o   (ost_ack)
  );

  tss_clk_switch #(.SYNC_STAGES(SYNC_STAGES)) u_switch (
    .clk_int    (clk_int),
    .clk_ext    (clk_ext),
    .rst_n      (rst_n),
    .want_int_i (want_int),
    .want_ext_i (want_ext),
    .core_clk_o (core_clk_o),
    .en_int_o   (en_int),
    .en_ext_o   (en_ext)
  );

  assign on_ext_o = en_ext;

endmodule

// File: rtl/tss_start_switch_chk.sv
module tss_start_switch_chk (
  input logic               clk_int,
  input logic               rst_n,
  input logic               sleep_i,
  input logic               wake_i,
  input logic [2:0]         osc_mode_i,
  input tss_pkg::sw_state_e state,
  input logic               en_int,
  input logic               en_ext
);
  import tss_pkg::*;

  // R9
  enable_excl_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(en_int && en_ext));

  // R8
  sleep_stop_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    sleep_i |=> (state == ST_SLEEP));

  // R2
  count_start_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (wake_i && !sleep_i && (state == ST_SLEEP || state == ST_WARM) && osc_mode_i <= 3'd2)
    |=> (state == ST_WARM));

  // R5
  direct_ext_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (wake_i && !sleep_i && state == ST_SLEEP && (osc_mode_i == 3'd3 || osc_mode_i == 3'd4))
    |=> (state == ST_RUN_EXT));

  // R6
  int_hold_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (state == ST_RUN_INT && !sleep_i) |=> (state == ST_RUN_INT));

endmodule

bind tss_start_switch tss_start_switch_chk u_chk (
  .clk_int    (clk_int),
  .rst_n      (rst_n),
  .sleep_i    (sleep_i),
  .wake_i     (wake_i),
  .osc_mode_i (osc_mode_i),
  .state      (sw_state),
  .en_int     (en_int),
  .en_ext     (en_ext)
);

// File: tb/tb_tss_start_switch.sv
module tb_tss_start_switch;

  localparam int SRC_OFF = 0, SRC_INT = 1, SRC_EXT = 2;

  logic       clk_int = 1'b0, clk_ext = 1'b0, rst_n = 1'b0;
  logic       sleep_i = 1'b0, wake_i = 1'b0;
  logic [2:0] osc_mode_i = 3'd1;
  logic       core_clk_o, on_ext_o;

  int  n_chk = 0, n_fail = 0, edges = 0, glitches = 0;
  bit  mon_busy = 1'b0, finished = 1'b0, seen_edge = 1'b0;
  realtime last_t = 0.0;

  typedef struct { int src; string req; } exp_t;
  exp_t exp_q[$];

  tss_start_switch dut (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n),
    .sleep_i(sleep_i), .wake_i(wake_i), .osc_mode_i(osc_mode_i),
    .core_clk_o(core_clk_o), .on_ext_o(on_ext_o)
  );

  // 250 MHz internal clock, slower external clock offset from it
  always #2 clk_int = ~clk_int;
  initial begin #1; forever #5 clk_ext = ~clk_ext; end

  always @(posedge core_clk_o) edges++;

  // R9: time every phase of the core clock
  always @(core_clk_o) begin
    if (seen_edge && ($realtime - last_t) < 1.9) glitches++;
    last_t    = $realtime;
    seen_edge = 1'b1;
  end

  function automatic int classify(input int n);
    if (n == 0) return SRC_OFF;
    if (n >= 20) return SRC_INT;
    if (n >= 8 && n <= 12) return SRC_EXT;
    return 3;
  endfunction

  // Monitor: pops an expected source, measures the core clock, compares
  initial begin
    forever begin
      exp_t it;
      int   e0, got;
      logic st;
      wait (exp_q.size() != 0);
      mon_busy = 1'b1;
      it = exp_q.pop_front();
      e0 = edges;
      #100;
      got = classify(edges - e0);
      st  = on_ext_o;
      n_chk++;
      if (got != it.src || st != (it.src == SRC_EXT)) begin
        n_fail++;
        $display("FAIL %s: source %0d status %0b, expected source %0d status %0b",
                 it.req, got, st, it.src, (it.src == SRC_EXT));
      end
      mon_busy = 1'b0;
    end
  end

  // Driver side of the scoreboard
  task automatic expect_src(input int src, input string req);
    exp_t it;
    it.src = src;
    it.req = req;
    exp_q.push_back(it);
    wait (exp_q.size() == 0 && !mon_busy);
  endtask

  task automatic pulse(input logic slp, input logic wk);
    @(negedge clk_int);
    sleep_i = slp;
    wake_i  = wk;
    @(negedge clk_int);
    sleep_i = 1'b0;
    wake_i  = 1'b0;
  endtask

  task automatic ext_wait(input int n);
    repeat (n) @(posedge clk_ext);
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #400000;
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run still busy, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk_int);
    rst_n = 1'b1;
    ext_wait(10);
    expect_src(SRC_OFF, "R1 reset state");

    // XT: internal at once, external after the count
    osc_mode_i = 3'd1;
    pulse(1'b0, 1'b1);
    ext_wait(4);
    expect_src(SRC_INT, "R2 XT wake on internal");
    ext_wait(986);
    expect_src(SRC_INT, "R3 before count end");
    ext_wait(50);
    expect_src(SRC_EXT, "R4 after count end");

    pulse(1'b1, 1'b0);
    ext_wait(20);
    expect_src(SRC_OFF, "R8 sleep stops clock");

    // LP with a restart part-way through the count
    osc_mode_i = 3'd0;
    pulse(1'b0, 1'b1);
    ext_wait(600);
    pulse(1'b0, 1'b1);
    ext_wait(1000);
    expect_src(SRC_INT, "R7 restart holds internal");
    ext_wait(50);
    expect_src(SRC_EXT, "R7 switch after restarted count");

    // sleep wins over a simultaneous wake
    pulse(1'b1, 1'b0);
    osc_mode_i = 3'd3;
    ext_wait(20);
    pulse(1'b1, 1'b1);
    ext_wait(20);
    expect_src(SRC_OFF, "R8 sleep priority");

    pulse(1'b0, 1'b1);
    ext_wait(20);
    expect_src(SRC_EXT, "R5 external-clock mode direct");

    pulse(1'b1, 1'b0);
    osc_mode_i = 3'd4;
    ext_wait(20);
    pulse(1'b0, 1'b1);
    ext_wait(20);
    expect_src(SRC_EXT, "R5 RC mode direct");

    pulse(1'b1, 1'b0);
    osc_mode_i = 3'd5;
    ext_wait(20);
    pulse(1'b0, 1'b1);
    ext_wait(4);
    expect_src(SRC_INT, "R6 internal mode");
    ext_wait(1100);
    expect_src(SRC_INT, "R6 internal mode holds");

    pulse(1'b1, 1'b0);
    osc_mode_i = 3'd7;
    ext_wait(20);
    pulse(1'b0, 1'b1);
    ext_wait(1100);
    expect_src(SRC_INT, "R6 unused code stays internal");

    // HS from the internal-only state: no effect until sleep and wake
    pulse(1'b1, 1'b0);
    osc_mode_i = 3'd2;
    ext_wait(20);
    pulse(1'b0, 1'b1);
    ext_wait(1060);
    expect_src(SRC_EXT, "R4 HS after count");

    n_chk++;
    if (glitches != 0) begin
      n_fail++;
      $display("FAIL R9 glitch-free: %0d short phases, expected 0", glitches);
    end

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule